// File: doc/BRIEF.md
# Four-Bank SDRAM Controller with Per-Bank Request Queues

This block sits between four requesters and a single-data-rate SDRAM built from four internal banks. Each requester owns one bank and one single-entry request holder: it presents an operation (read or write), a row, a column and, for writes, a data word, and pulses its push line while its ready line is high. A fixed-priority arbiter chooses one waiting holder, and the command sequencer turns that choice into an activate, a column access and a precharge on the memory's command, bank and address pins. A data path drives write data onto the data bus and captures read data from it.

After reset the sequencer brings the memory up before it serves anyone. It waits a power-up delay, closes all banks, issues two refresh commands and loads the mode register. In service it keeps a refresh timer and inserts an auto-refresh between accesses whenever the timer has expired. Only one row is open at any time, and every access closes its row before the next command. The parameters T_RCD, T_RP, T_RFC and T_MRD must each be at least 2, CAS_LAT at least 1, COL_W no more than 10 and ADDR_W at least 11.

Top module: `sdram_bank_ctrl`

## Requirements
- R1: After reset the command pins show NOP for exactly PWRUP_CYC cycles. Then the controller issues, in this order, PRECHARGE, AUTO REFRESH, AUTO REFRESH and LOAD MODE. No ACTIVE, READ or WRITE is issued before `init_done` is high.
- R2: The commands on {ras_n, cas_n, we_n} are encoded as ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, AUTO REFRESH=001, LOAD MODE=000 and NOP=111.
- R3: When several holders are waiting, bank 0 is served first and bank 3 last.
- R4: A holder accepts a push only while its `req_ready` bit is high. A push while the holder waits is ignored and changes nothing stored. The holder frees itself (ready high again) in the cycle its response appears.
- R5: An access is an ACTIVE carrying the bank on `sd_ba` and the row on `sd_addr`, followed exactly T_RCD cycles later by a READ or WRITE to the same bank. That command carries the column on the low `sd_addr` bits and has A10 low. READ or WRITE goes only to a bank that is currently open.
- R6: Read data present on `sd_dq_i` CAS_LAT cycles after READ is returned on `resp_rdata`, with `resp_valid` high and `resp_we` low, CAS_LAT+1 cycles after the READ.
- R7: `sd_dq_oe` is high exactly in WRITE cycles, and `sd_dq_o` then carries the requester's data. The write response (`resp_we` high) appears in the WRITE cycle.
- R8: Every PRECHARGE has A10 high. No command follows a PRECHARGE sooner than T_RP cycles, and none follows an AUTO REFRESH sooner than T_RFC cycles.
- R9: After initialization an AUTO REFRESH is issued about every REF_INT cycles, only while no row is open. It is issued ahead of any waiting request, even under continuous load.
- R10: At most one bank is open at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_push | input | NB | Per-bank request strobe |
| req_we | input | NB | Per-bank operation, 1 = write |
| req_row | input | NB*ROW_W | Per-bank row, bank i at bits [i*ROW_W +: ROW_W] |
| req_col | input | NB*COL_W | Per-bank column, same packing |
| req_wdata | input | NB*DW | Per-bank write data, same packing |
| req_ready | output | NB | Holder of bank i is empty |
| resp_valid | output | 1 | Response pulse |
| resp_we | output | 1 | Response belongs to a write |
| resp_bank | output | BA_W | Bank of the response |
| resp_rdata | output | DW | Read data |
| init_done | output | 1 | Power-up sequence complete |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dq_o | output | DW | Write data to memory |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_i | input | DW | Read data from memory |

## Verification
The in-line assertions watch several rules on every cycle. No row or column command may appear before initialization ends. A10 must be set on every precharge. At most one bank is open, and column commands reach only an open bank that has waited out tRCD. The data drive enable must coincide with WRITE. The arbiter's grant must be the lowest-numbered waiting bank, a waiting holder must keep its contents, and a pending refresh may clear only as AUTO REFRESH goes out. Other behaviour shows only in the bench's scenarios, which run against a behavioural memory responder. These cover data integrity across banks and rows, the exact power-up order and delay, the order of service under contention, refresh spacing under sustained load, and the read response latency.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } sd_cmd_e;

  typedef enum logic [3:0] {
    M_PWR,
    M_IPRE_WAIT,
    M_IREF,
    M_MRS,
    M_WAIT,
    M_IDLE,
    M_RW,
    M_CAP,
    M_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    B_IDLE,
    B_RCD,
    B_OPEN
  } bank_state_e;

endpackage

// File: rtl/sdc_req_buf.sv
module sdc_req_buf #(
  parameter int ROW_W = 13,
  parameter int COL_W = 9,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             push_we,
  input  logic [ROW_W-1:0] push_row,
  input  logic [COL_W-1:0] push_col,
  input  logic [DW-1:0]    push_wdata,
  input  logic             clr,
  output logic             pend,
  output logic             we,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic [DW-1:0]    wdata
);

  // Occupancy flag has a reset; the payload registers need none.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (clr) begin
      pend <= 1'b0;
    end else if (push && !pend) begin
      pend <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pend) begin
      we    <= push_we;
      row   <= push_row;
      col   <= push_col;
      wdata <= push_wdata;
    end
  end

  // R4: a waiting entry is never overwritten by a later push
  assert_hold_while_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (pend && !clr) |=> $stable({we, row, col, wdata}));

endmodule

// File: rtl/sdc_sched.sv
module sdc_sched #(
  parameter int NB   = 4,
  parameter int BA_W = $clog2(NB)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NB-1:0]   pend,
  output logic [NB-1:0]   gnt_oh,
  output logic [BA_W-1:0] gnt_bank,
  output logic            gnt_any
);

  // Fixed priority: the lowest index wins.
  always_comb begin
    gnt_oh   = '0;
    gnt_bank = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (pend[i]) begin
        gnt_oh   = '0;
        gnt_oh[i] = 1'b1;
        gnt_bank = BA_W'(i);
      end
    end
  end

  assign gnt_any = |pend;

  assert_grant_single_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_oh) && ((gnt_oh & ~pend) == '0));

  generate
    for (genvar g = 1; g < NB; g++) begin : g_prio_chk
      // R3: a higher bank never wins over a waiting lower one
      assert_priority_order_R3: assert property (@(posedge clk) disable iff (rst)
        gnt_oh[g] |-> (pend[g-1:0] == '0));
    end
  endgenerate

endmodule

// File: rtl/sdc_bank_fsm.sv
module sdc_bank_fsm import sdc_pkg::*; #(
  parameter int T_RCD = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  input  logic rw,
  input  logic pre,
  output logic is_open
);

  localparam int BW = $clog2(T_RCD + 1) + 1;

  bank_state_e   st;
  logic [BW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= B_IDLE;
      bcnt <= '0;
    end else if (pre) begin
      st <= B_IDLE;
    end else begin
      case (st)
        B_IDLE: if (act) begin
          st   <= B_RCD;
          bcnt <= BW'(T_RCD - 2);
        end
        B_RCD: begin
          if (bcnt == '0) st <= B_OPEN;
          else            bcnt <= bcnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign is_open = (st != B_IDLE);

  // R5: a column access reaches this bank only after tRCD has elapsed
  assert_rw_after_rcd_R5: assert property (@(posedge clk) disable iff (rst)
    rw |-> (st == B_OPEN));

  // R10: an activate never lands on a bank that is already open
  assert_act_on_closed_R10: assert property (@(posedge clk) disable iff (rst)
    act |-> (st == B_IDLE));

endmodule

// File: rtl/sdc_data.sv
module sdc_data #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_go,
  input  logic [DW-1:0] wdata,
  input  logic          rd_cap,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) dq_oe <= 1'b0;
    else     dq_oe <= wr_go;
  end

  always_ff @(posedge clk) begin
    if (wr_go)  dq_o  <= wdata;
    if (rd_cap) rdata <= dq_i;
  end

endmodule

// File: rtl/sdc_main.sv
module sdc_main import sdc_pkg::*; #(
  parameter int NB        = 4,
  parameter int BA_W      = $clog2(NB),
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int PWRUP_CYC = 100,
  parameter int REF_INT   = 780,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 4,
  parameter int T_MRD     = 2,
  parameter int CAS_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt_any,
  input  logic [BA_W-1:0]   gnt_bank,
  input  logic              sel_we,
  input  logic [ROW_W-1:0]  sel_row,
  input  logic [COL_W-1:0]  sel_col,
  output logic [2:0]        cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              init_done,
  output logic              take,
  output logic [BA_W-1:0]   cur_bank,
  output logic              rw_go,
  output logic              wr_go,
  output logic              rd_cap,
  output logic              pre_go,
  output logic              done,
  output logic              resp_valid,
  output logic              resp_we,
  output logic [BA_W-1:0]   resp_bank
);

  localparam int CW  = $clog2(PWRUP_CYC + T_RFC + T_RP + T_RCD + T_MRD + CAS_LAT + 2) + 1;
  localparam int RCW = $clog2(REF_INT + 1) + 1;
  localparam logic [ADDR_W-1:0] A10_SET   = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_WORD = ADDR_W'(CAS_LAT << 4);

  seq_state_e       state, nxt;
  sd_cmd_e          cmd;
  logic [CW-1:0]    cnt;
  logic             second_ref;
  logic             cur_we;
  logic [COL_W-1:0] cur_col;
  logic [RCW-1:0]   rcnt;
  logic             ref_pend;
  logic             ref_ack;

  assign cmd_o   = cmd;
  assign ref_ack = (state == M_IDLE) && ref_pend;
  assign take    = (state == M_IDLE) && !ref_pend && gnt_any;
  assign rw_go   = (state == M_RW);
  assign wr_go   = (state == M_RW) && cur_we;
  assign rd_cap  = (state == M_CAP);
  assign pre_go  = ((state == M_PWR) && (cnt == '0)) || (state == M_CAP) || (state == M_PRE);
  assign done    = ((state == M_RW) && cur_we) || (state == M_CAP);

  // Refresh interval timer; it runs once initialization has finished.
  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt     <= '0;
      ref_pend <= 1'b0;
    end else if (init_done) begin
      if (rcnt == RCW'(REF_INT - 1)) begin
        rcnt     <= '0;
        ref_pend <= 1'b1;
      end else begin
        rcnt <= rcnt + 1'b1;
        if (ref_ack) ref_pend <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= M_PWR;
      nxt        <= M_IDLE;
      cnt        <= CW'(PWRUP_CYC - 1);
      cmd        <= CMD_NOP;
      ba_o       <= '0;
      addr_o     <= '0;
      init_done  <= 1'b0;
      second_ref <= 1'b0;
      cur_we     <= 1'b0;
      cur_bank   <= '0;
      cur_col    <= '0;
      resp_valid <= 1'b0;
      resp_we    <= 1'b0;
      resp_bank  <= '0;
    end else begin
      cmd        <= CMD_NOP;
      resp_valid <= 1'b0;
      case (state)
        M_PWR: begin
          if (cnt == '0) begin
            cmd    <= CMD_PRE;
            addr_o <= A10_SET;
            cnt    <= CW'(T_RP - 2);
            nxt    <= M_IREF;
            state  <= M_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        M_IREF: begin
          cmd        <= CMD_REF;
          cnt        <= CW'(T_RFC - 2);
          nxt        <= second_ref ? M_MRS : M_IREF;
          second_ref <= 1'b1;
          state      <= M_WAIT;
        end
        M_MRS: begin
          cmd    <= CMD_MRS;
          addr_o <= MODE_WORD;
          ba_o   <= '0;
          cnt    <= CW'(T_MRD - 2);
          nxt    <= M_IDLE;
          state  <= M_WAIT;
        end
        M_WAIT: begin
          if (cnt == '0) state <= nxt;
          else           cnt   <= cnt - 1'b1;
        end
        M_IDLE: begin
          init_done <= 1'b1;
          if (ref_pend) begin
            cmd   <= CMD_REF;
            cnt   <= CW'(T_RFC - 2);
            nxt   <= M_IDLE;
            state <= M_WAIT;
          end else if (gnt_any) begin
            cmd      <= CMD_ACT;
            ba_o     <= gnt_bank;
            addr_o   <= ADDR_W'(sel_row);
            cur_bank <= gnt_bank;
            cur_we   <= sel_we;
            cur_col  <= sel_col;
            cnt      <= CW'(T_RCD - 2);
            nxt      <= M_RW;
            state    <= M_WAIT;
          end
        end
        M_RW: begin
          ba_o   <= cur_bank;
          addr_o <= ADDR_W'(cur_col);
          if (cur_we) begin
            cmd        <= CMD_WR;
            resp_valid <= 1'b1;
            resp_we    <= 1'b1;
            resp_bank  <= cur_bank;
            state      <= M_PRE;
          end else begin
            cmd   <= CMD_RD;
            cnt   <= CW'(CAS_LAT - 1);
            nxt   <= M_CAP;
            state <= M_WAIT;
          end
        end
        M_CAP: begin
          resp_valid <= 1'b1;
          resp_we    <= 1'b0;
          resp_bank  <= cur_bank;
          cmd        <= CMD_PRE;
          addr_o     <= A10_SET;
          cnt        <= CW'(T_RP - 2);
          nxt        <= M_IDLE;
          state      <= M_WAIT;
        end
        M_PRE: begin
          cmd    <= CMD_PRE;
          addr_o <= A10_SET;
          cnt    <= CW'(T_RP - 2);
          nxt    <= M_IDLE;
          state  <= M_WAIT;
        end
        default: state <= M_IDLE;
      endcase
    end
  end

  // R1: no row or column command before the power-up sequence ends
  assert_no_access_before_init_R1: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !(cmd inside {CMD_ACT, CMD_RD, CMD_WR}));

  // R8: every precharge closes all banks
  assert_pre_all_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE) |-> addr_o[10]);

  // R5: column commands never request auto-precharge
  assert_col_a10_low_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd inside {CMD_RD, CMD_WR}) |-> !addr_o[10]);

  // R9: a pending refresh is retired only by issuing AUTO REFRESH
  assert_ref_retire_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_pend) |-> (cmd == CMD_REF));

endmodule

// File: rtl/sdram_bank_ctrl.sv
module sdram_bank_ctrl import sdc_pkg::*; #(
  parameter int NB        = 4,
  parameter int BA_W      = $clog2(NB),
  parameter int ROW_W     = 13,
  parameter int COL_W     = 9,
  parameter int ADDR_W    = 13,
  parameter int DW        = 16,
  parameter int PWRUP_CYC = 100,
  parameter int REF_INT   = 780,
  parameter int T_RCD     = 2,
  parameter int T_RP      = 2,
  parameter int T_RFC     = 4,
  parameter int T_MRD     = 2,
  parameter int CAS_LAT   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NB-1:0]       req_push,
  input  logic [NB-1:0]       req_we,
  input  logic [NB*ROW_W-1:0] req_row,
  input  logic [NB*COL_W-1:0] req_col,
  input  logic [NB*DW-1:0]    req_wdata,
  output logic [NB-1:0]       req_ready,
  output logic                resp_valid,
  output logic                resp_we,
  output logic [BA_W-1:0]     resp_bank,
  output logic [DW-1:0]       resp_rdata,
  output logic                init_done,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [BA_W-1:0]     sd_ba,
  output logic [ADDR_W-1:0]   sd_addr,
  output logic [DW-1:0]       sd_dq_o,
  output logic                sd_dq_oe,
  input  logic [DW-1:0]       sd_dq_i
);

  logic [NB-1:0]    pend, b_we, bank_open, gnt_oh;
  logic [ROW_W-1:0] b_row   [NB];
  logic [COL_W-1:0] b_col   [NB];
  logic [DW-1:0]    b_wdata [NB];
  logic [BA_W-1:0]  gnt_bank, cur_bank;
  logic             gnt_any, take, rw_go, wr_go, rd_cap, pre_go, done;
  logic [2:0]       cmd;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      sdc_req_buf #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW)) i_buf (
        .clk        (clk),
        .rst        (rst),
        .push       (req_push[g]),
        .push_we    (req_we[g]),
        .push_row   (req_row[g*ROW_W +: ROW_W]),
        .push_col   (req_col[g*COL_W +: COL_W]),
        .push_wdata (req_wdata[g*DW +: DW]),
        .clr        (done && (cur_bank == BA_W'(g))),
        .pend       (pend[g]),
        .we         (b_we[g]),
        .row        (b_row[g]),
        .col        (b_col[g]),
        .wdata      (b_wdata[g])
      );

      sdc_bank_fsm #(.T_RCD(T_RCD)) i_bank (
        .clk     (clk),
        .rst     (rst),
        .act     (take && (gnt_bank == BA_W'(g))),
        .rw      (rw_go && (cur_bank == BA_W'(g))),
        .pre     (pre_go),
        .is_open (bank_open[g])
      );
    end
  endgenerate

  assign req_ready = ~pend;

  sdc_sched #(.NB(NB), .BA_W(BA_W)) i_sched (
    .clk      (clk),
    .rst      (rst),
    .pend     (pend),
    .gnt_oh   (gnt_oh),
    .gnt_bank (gnt_bank),
    .gnt_any  (gnt_any)
  );

  sdc_main #(
    .NB(NB), .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .PWRUP_CYC(PWRUP_CYC), .REF_INT(REF_INT), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT)
  ) i_main (
    .clk        (clk),
    .rst        (rst),
    .gnt_any    (gnt_any),
    .gnt_bank   (gnt_bank),
    .sel_we     (b_we[gnt_bank]),
    .sel_row    (b_row[gnt_bank]),
    .sel_col    (b_col[gnt_bank]),
    .cmd_o      (cmd),
    .ba_o       (sd_ba),
    .addr_o     (sd_addr),
    .init_done  (init_done),
    .take       (take),
    .cur_bank   (cur_bank),
    .rw_go      (rw_go),
    .wr_go      (wr_go),
    .rd_cap     (rd_cap),
    .pre_go     (pre_go),
    .done       (done),
    .resp_valid (resp_valid),
    .resp_we    (resp_we),
    .resp_bank  (resp_bank)
  );

  sdc_data #(.DW(DW)) i_data (
    .clk    (clk),
    .rst    (rst),
    .wr_go  (wr_go),
    .wdata  (b_wdata[cur_bank]),
    .rd_cap (rd_cap),
    .dq_i   (sd_dq_i),
    .dq_o   (sd_dq_o),
    .dq_oe  (sd_dq_oe),
    .rdata  (resp_rdata)
  );

  assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R10: only one row is open at any time
  assert_single_open_row_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_open));

  // R5: column commands address an open bank
  assert_rw_to_open_bank_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_RD || cmd == CMD_WR) |-> bank_open[sd_ba]);

  // R7: the data bus is driven in WRITE cycles and nowhere else
  assert_dq_drive_write_R7: assert property (@(posedge clk) disable iff (rst)
    sd_dq_oe == (cmd == CMD_WR));

  // R9: refresh is issued only with every row closed
  assert_ref_rows_closed_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_REF) |-> (bank_open == '0));

endmodule

// File: tb/test_sdram_bank_ctrl.sv
module test_sdram_bank_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, BA_W = 2, ROW_W = 13, COL_W = 9, ADDR_W = 13, DW = 16;
  localparam int PWRUP = 20, REF_INT = 150, T_RCD = 3, T_RP = 2, T_RFC = 4;
  localparam int T_MRD = 2, CL = 2;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010,
                         C_ACT = 3'b011, C_WR = 3'b100, C_RD = 3'b101, C_NOP = 3'b111;

  logic clk = 1'b0, rst = 1'b1;
  logic [NB-1:0] req_push = '0, req_we = '0, req_ready;
  logic [NB*ROW_W-1:0] req_row = '0;
  logic [NB*COL_W-1:0] req_col = '0;
  logic [NB*DW-1:0] req_wdata = '0;
  logic resp_valid, resp_we, init_done, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BA_W-1:0] resp_bank, sd_ba;
  logic [DW-1:0] resp_rdata, sd_dq_o, sd_dq_i;
  logic [ADDR_W-1:0] sd_addr;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sdram_bank_ctrl #(
    .NB(NB), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .DW(DW),
    .PWRUP_CYC(PWRUP), .REF_INT(REF_INT), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .CAS_LAT(CL)
  ) i_sdram_bank_ctrl (
    .clk(clk), .rst(rst), .req_push(req_push), .req_we(req_we), .req_row(req_row),
    .req_col(req_col), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_we(resp_we), .resp_bank(resp_bank),
    .resp_rdata(resp_rdata), .init_done(init_done), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
    .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i)
  );

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Behavioural memory responder and protocol monitor
  logic [15:0] mem [256];
  logic [ROW_W-1:0] open_row [NB];
  logic [DW-1:0] rp0 = '0, rp1 = '0;
  assign sd_dq_i = rp1;

  int cyc = 0, last_act = -1000, last_pre = -1000, last_ref = -1000, last_rd = -1000;
  int nops = 0, seq_n = 0, act_ba = 0, row_open = 0;
  int v_rcd = 0, v_gap = 0, v_a10 = 0, v_dq = 0, v_lat = 0, v_refgap = 0, v_early = 0;
  int refs_post = 0;
  logic [2:0] seq [4];

  function automatic int midx(input logic [1:0] b, input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    return int'({b, r[2:0], c[2:0]});
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(posedge clk) begin
    logic [2:0] c;
    c = {sd_ras_n, sd_cas_n, sd_we_n};
    rp0 <= '0;
    rp1 <= rp0;
    if (!rst) begin
      cyc++;
      if (c != C_NOP && seq_n < 4) begin seq[seq_n] = c; seq_n++; end
      else if (c == C_NOP && seq_n == 0) nops++;
      if (c != C_NOP && c != C_RD && c != C_WR && c != C_PRE) begin
        if (cyc - last_pre < T_RP) v_gap++;
        if (cyc - last_ref < T_RFC) v_gap++;
      end
      if (!init_done && (c == C_ACT || c == C_RD || c == C_WR)) v_early++;
      if (sd_dq_oe != (c == C_WR)) v_dq++;
      case (c)
        C_ACT: begin
          last_act = cyc; act_ba = int'(sd_ba);
          open_row[sd_ba] = sd_addr; row_open = 1;
        end
        C_RD, C_WR: begin
          if (cyc - last_act != T_RCD || int'(sd_ba) != act_ba || sd_addr[10]) v_rcd++;
          if (c == C_RD) begin
            last_rd = cyc;
            rp0 <= mem[midx(sd_ba, open_row[sd_ba], sd_addr[COL_W-1:0])];
          end else begin
            mem[midx(sd_ba, open_row[sd_ba], sd_addr[COL_W-1:0])] = sd_dq_o;
          end
        end
        C_PRE: begin
          if (!sd_addr[10]) v_a10++;
          last_pre = cyc; row_open = 0;
        end
        C_REF: begin
          if (row_open != 0) v_refgap++;
          if (init_done) begin
            refs_post++;
            if (cyc - last_ref > REF_INT + 20 || cyc - last_ref < REF_INT - 20) v_refgap++;
          end
          last_ref = cyc;
        end
        default: ;
      endcase
      if (resp_valid && !resp_we && (cyc - last_rd != CL + 1)) v_lat++;
      if (resp_valid && resp_we && c != C_WR) v_dq++;
    end
  end

  // Drive a one-cycle push for one bank
  task automatic push1(input int b, input bit we, input int row, input int col, input logic [15:0] wd);
    @(negedge clk);
    req_push = '0;
    req_push[b] = 1'b1;
    req_we[b] = we;
    req_row[b*ROW_W +: ROW_W] = ROW_W'(row);
    req_col[b*COL_W +: COL_W] = COL_W'(col);
    req_wdata[b*DW +: DW] = wd;
    @(negedge clk);
    req_push = '0;
  endtask

  task automatic wait_resp(output int b, output bit we, output logic [15:0] d, output bit ok);
    ok = 1'b0; b = -1; we = 1'b0; d = '0;
    for (int t = 0; t < 300; t++) begin
      if (resp_valid) begin
        b = int'(resp_bank); we = resp_we; d = resp_rdata; ok = 1'b1;
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  // Table: {bank[40:39], we[38], row[37:35], col[34:32], wdata[31:16], expected[15:0]}
  localparam logic [40:0] VEC [10] = '{
    {2'd0, 1'b1, 3'd1, 3'd2, 16'hA001, 16'h0000},
    {2'd1, 1'b1, 3'd2, 3'd3, 16'hB002, 16'h0000},
    {2'd2, 1'b1, 3'd3, 3'd4, 16'hC003, 16'h0000},
    {2'd3, 1'b1, 3'd4, 3'd5, 16'hD004, 16'h0000},
    {2'd0, 1'b0, 3'd1, 3'd2, 16'h0000, 16'hA001},
    {2'd3, 1'b0, 3'd4, 3'd5, 16'h0000, 16'hD004},
    {2'd1, 1'b1, 3'd2, 3'd3, 16'h1234, 16'h0000},
    {2'd1, 1'b0, 3'd2, 3'd3, 16'h0000, 16'h1234},
    {2'd2, 1'b0, 3'd3, 3'd4, 16'h0000, 16'hC003},
    {2'd0, 1'b0, 3'd5, 3'd0, 16'h0000, 16'h0000}
  };

  initial begin
    #(CLK_PERIOD * 60000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int b; bit we, ok; logic [15:0] d;
    int order [3]; logic [15:0] odat [3];
    int refs0;

    repeat (3) @(negedge clk);
    // Reset state (R1, R2: NOP = 111)
    check({sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2 reset cmd NOP", {sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    check(init_done == 1'b0, "R1 init_done low in reset", init_done, 0);
    check(req_ready == 4'hF && !resp_valid && !sd_dq_oe, "R4 holders empty in reset",
          {req_ready, resp_valid, sd_dq_oe}, 6'b111100);
    rst = 1'b0;

    for (int t = 0; t < 200 && !init_done; t++) @(negedge clk);
    check(init_done == 1'b1, "R1 init_done rises", init_done, 1);
    check(nops == PWRUP, "R1 power-up NOP count", nops, PWRUP);
    check(seq[0] == C_PRE && seq[1] == C_REF && seq[2] == C_REF && seq[3] == C_MRS,
          "R1 R2 init order", {seq[0], seq[1], seq[2], seq[3]}, {C_PRE, C_REF, C_REF, C_MRS});

    // Vector table: R5 R6 R7 data round-trips
    for (int i = 0; i < 10; i++) begin
      push1(int'(VEC[i][40:39]), VEC[i][38], int'(VEC[i][37:35]), int'(VEC[i][34:32]), VEC[i][31:16]);
      wait_resp(b, we, d, ok);
      if (VEC[i][38])
        check(ok && b == int'(VEC[i][40:39]) && we, $sformatf("R7 write vec %0d", i), b, VEC[i][40:39]);
      else
        check(ok && b == int'(VEC[i][40:39]) && !we && d == VEC[i][15:0],
              $sformatf("R6 read vec %0d", i), d, VEC[i][15:0]);
    end

    // R3: three banks waiting at once are served lowest first
    @(negedge clk);
    req_we = '0;
    req_row[3*ROW_W +: ROW_W] = 4; req_col[3*COL_W +: COL_W] = 5;
    req_row[2*ROW_W +: ROW_W] = 3; req_col[2*COL_W +: COL_W] = 4;
    req_row[1*ROW_W +: ROW_W] = 2; req_col[1*COL_W +: COL_W] = 3;
    req_push = 4'b1110;
    @(negedge clk);
    req_push = '0;
    for (int k = 0; k < 3; k++) begin
      wait_resp(b, we, d, ok);
      order[k] = ok ? b : -1; odat[k] = d;
    end
    check(order[0] == 1 && order[1] == 2 && order[2] == 3, "R3 service order",
          {order[0][3:0], order[1][3:0], order[2][3:0]}, 12'h123);
    check(odat[0] == 16'h1234 && odat[1] == 16'hC003 && odat[2] == 16'hD004, "R3 R6 contention data",
          odat[0], 16'h1234);

    // R4: second push to a waiting holder is ignored
    push1(2, 1'b1, 6, 6, 16'h5555);
    check(req_ready[2] == 1'b0, "R4 ready low while waiting", req_ready[2], 0);
    push1(2, 1'b1, 6, 6, 16'h6666);
    wait_resp(b, we, d, ok);
    check(ok && b == 2 && we && req_ready[2], "R4 freed after response", req_ready[2], 1);
    for (int t = 0; t < 10; t++) @(negedge clk);
    check(!resp_valid && req_ready == 4'hF, "R4 no second response", {resp_valid, req_ready}, 5'h0F);
    push1(2, 1'b0, 6, 6, 16'h0000);
    wait_resp(b, we, d, ok);
    check(ok && d == 16'h5555, "R4 stored data kept", d, 16'h5555);

    // R9: continuous load on every bank, refresh must still appear
    refs0 = refs_post;
    for (int t = 0; t < 500; t++) begin
      req_push = '0;
      for (int q = 0; q < NB; q++) begin
        if (req_ready[q]) begin
          req_push[q] = 1'b1; req_we[q] = 1'b0;
          req_row[q*ROW_W +: ROW_W] = ROW_W'(q); req_col[q*COL_W +: COL_W] = '0;
        end
      end
      @(negedge clk);
    end
    req_push = '0;
    for (int t = 0; t < 100 && req_ready != 4'hF; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    check(refs_post - refs0 >= 2, "R9 refresh under load", refs_post - refs0, 2);
    check(req_ready == 4'hF, "R4 load drained", req_ready, 4'hF);

    // Protocol monitor tallies
    check(v_rcd == 0, "R5 tRCD, bank and A10 on column command", v_rcd, 0);
    check(v_lat == 0, "R6 read response latency", v_lat, 0);
    check(v_dq == 0, "R7 data drive only in WRITE", v_dq, 0);
    check(v_a10 == 0, "R8 A10 high on precharge", v_a10, 0);
    check(v_gap == 0, "R8 tRP and tRFC spacing", v_gap, 0);
    check(v_refgap == 0, "R9 refresh spacing with rows closed", v_refgap, 0);
    check(v_early == 0, "R1 no access before init", v_early, 0);
    check(refs_post >= 3, "R9 periodic refresh count", refs_post, 3);
    check(row_open == 0, "R10 rows closed at rest", row_open, 0);

    finish_run();
  end

endmodule